// File: doc/BRIEF.md
# Serial Peripheral Port with Sticky Status Flags

This block is an 8-bit SPI port that works either as the bus master or as a selected slave. A CPU drives it through a small register bus with two addresses. Address 0 holds the control and status byte. Address 1 is the data byte: a write loads the byte to transmit, and a read returns the last received byte. Each transfer moves one byte, most significant bit first, in clock mode 0. SCK idles low, data is sampled on the rising SCK edge, and data changes on the falling SCK edge.

In master mode the port makes SCK from the system clock, with each SCK half period lasting `SCK_HALF` system clocks, and shifts data out on `mosiOut`. In slave mode the external select, clock and data inputs pass through multi-stage synchronizers before they are used, and the port returns data on `misoOut`. Hardware detects four conditions and records each one as a sticky flag: end of transfer, write collision, mode fault and receive overrun. Only a software write clears these flags, and while any of them is set the interrupt request is high.

Top module: `spiPort`

## Requirements
- R1: After reset the control/status byte reads 0x00, `irq` is 0 and `sckOut` is 0.
- R2: The control/status byte has these fields: bit7 done, bit6 collision, bit5 fault, bit4 overrun, bit3 busy, bit2 selected, bit1 master enable, bit0 port enable. Bits 3 and 2 are read-only and ignore writes. Every other bit reads back the value last written, unless hardware has since set it.
- R3: The done flag (bit7) is set at the end of every transfer, in master or slave mode. Hardware never clears it, and it stays set until software writes 0 to it. `irq` is 1 exactly while any of bits 7 to 4 is 1.
- R4: A data write while a transfer is in progress sets the collision flag (bit6) and is discarded, so the transfer in progress sends its original byte.
- R5: When the port is enabled, master mode is enabled and the select input is low, the fault flag (bit5) is set. Any master transfer in progress is aborted: busy goes to 0, SCK goes low and the done flag is not set.
- R6: If a transfer ends while the receive buffer still holds an unread byte, the overrun flag (bit4) is set. The buffer keeps its old byte and the new byte is dropped.
- R7: The busy flag (bit3) is 1 for the whole of a master transfer and 0 when it ends. `sckOut` is low whenever busy is 0.
- R8: In master mode a data write starts an 8-bit transfer, MSB first. SCK is high for `SCK_HALF` system clocks in each bit, so for 8*`SCK_HALF` clocks in a byte. The byte sampled from `masterMiso` can then be read from address 1, and that read marks the buffer empty.
- R9: In slave mode with the select input low, the port samples the synchronized slave data input on rising SCK. It presents on `misoOut` the byte last written, MSB first. The selected flag (bit2) reads 1 while the select input is low and 0 while it is high.
- R10: With the port enable (bit0) at 0, SCK activity on the slave inputs starts no transfer, sets no flag and leaves the receive buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a data read marks the buffer empty) |
| regAddr | input | 1 | 0 selects control/status, 1 selects data |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid in the cycle regRdEn is high |
| irq | output | 1 | Interrupt request, OR of the four sticky flags |
| sckOut | output | 1 | Master-mode serial clock |
| mosiOut | output | 1 | Master-mode serial data out |
| masterMiso | input | 1 | Master-mode serial data in |
| nssIn | input | 1 | Active-low select input |
| slaveSck | input | 1 | Slave-mode serial clock (asynchronous) |
| slaveMosi | input | 1 | Slave-mode serial data in (asynchronous) |
| misoOut | output | 1 | Slave-mode serial data out |
| misoDrive | output | 1 | High when misoOut should drive the line |

## Verification
Assertions check the following on every cycle:
- SCK stays low while the port is idle, and busy drops once master mode or the port is switched off.
- The done flag is set after each completed transfer and stays set until a control write.
- A data write during a transfer raises the collision flag.
- A selected master raises the fault flag and stops.
- An overrun keeps the old buffer contents.
- A disabled port completes no transfer.

Only the bench scenarios can show the rest:
- The serial bit order and data values.
- The MISO byte presented in slave mode.
- That a colliding byte never reaches the line.
- The SCK high time.
- Which byte survives an overrun when the buffer is read.

// File: rtl/spiPortPkg.sv
package spiPortPkg;
  localparam int unsigned BYTE_W = 8;

  // field positions of the control/status byte
  localparam int unsigned F_DONE = 7;
  localparam int unsigned F_WCOL = 6;
  localparam int unsigned F_FALT = 5;
  localparam int unsigned F_OVRN = 4;
  localparam int unsigned F_BUSY = 3;
  localparam int unsigned F_SEL  = 2;
  localparam int unsigned F_MST  = 1;
  localparam int unsigned F_EN   = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;     // copy write data into shifter
    logic sampleBit;  // capture incoming serial bit
    logic shiftBit;   // shift captured bit into shifter
    logic commitRx;   // move completed byte into receive buffer
    logic fromMaster; // choose master-side data input
  } dpStrobeT;
endpackage

// File: rtl/spiPortDatapath.sv
module spiPortDatapath
  import spiPortPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [BYTE_W-1:0] txData,
  input  logic              masterMiso,
  input  logic              nssIn,
  input  logic              slaveSck,
  input  logic              slaveMosi,
  output logic              shiftMsb,
  output logic [BYTE_W-1:0] rxBuf,
  output logic              nssSync,
  output logic              slvSckRise,
  output logic              slvSckFall
);
  localparam int unsigned NSYNC = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NSYNC-1:0] nssPipe, sckPipe, mosiPipe;
  logic sckPrev;
  logic sampled;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] shiftNext;

  // synchronizer chains; select resets to deasserted
  generate
    for (genvar s = 0; s < NSYNC; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          nssPipe[s]  <= 1'b1;
          sckPipe[s]  <= 1'b0;
          mosiPipe[s] <= 1'b0;
        end else if (s == 0) begin
          nssPipe[s]  <= nssIn;
          sckPipe[s]  <= slaveSck;
          mosiPipe[s] <= slaveMosi;
        end else begin
          nssPipe[s]  <= nssPipe[s-1];
          sckPipe[s]  <= sckPipe[s-1];
          mosiPipe[s] <= mosiPipe[s-1];
        end
      end
    end
  endgenerate

  assign nssSync    = nssPipe[NSYNC-1];
  assign slvSckRise = sckPipe[NSYNC-1] & ~sckPrev;
  assign slvSckFall = ~sckPipe[NSYNC-1] & sckPrev;
  assign shiftNext  = {shiftReg[BYTE_W-2:0], sampled};
  assign shiftMsb   = shiftReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      sampled  <= 1'b0;
      shiftReg <= '0;
      rxBuf    <= '0;
    end else begin
      sckPrev <= sckPipe[NSYNC-1];
      if (strobe.sampleBit)
        sampled <= strobe.fromMaster ? masterMiso : mosiPipe[NSYNC-1];
      if (strobe.loadTx)
        shiftReg <= txData;
      else if (strobe.shiftBit)
        shiftReg <= shiftNext;
      if (strobe.commitRx)
        rxBuf <= shiftNext;
    end
  end
endmodule

// File: rtl/spiPortCtrl.sv
module spiPortCtrl
  import spiPortPkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              nssSync,
  input  logic              slvSckRise,
  input  logic              slvSckFall,
  output dpStrobeT          strobe,
  output logic [BYTE_W-1:0] ctrlView,
  output logic              sckOut,
  output logic              busy,
  output logic              xferDone,
  output logic              inProgress,
  output logic              rxFull,
  output logic              irq
);
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam int unsigned DIV_W  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

  logic spiEn, mstEn, fDone, fWcol, fFalt, fOvrn;
  logic sckReg;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;

  logic ctrlWr, dataWr, dataRd;
  logic faultNow, abortNow, startNow;
  logic halfTick, mRise, mFall, mDone;
  logic slvOn, sRise, sFall, sDone;
  logic rxFullEff;

  assign ctrlWr = regWrEn & ~regAddr;
  assign dataWr = regWrEn & regAddr;
  assign dataRd = regRdEn & regAddr;

  // master sequencing
  assign halfTick = busy && (divCnt == DIV_LAST);
  assign mRise    = halfTick & ~sckReg;
  assign mFall    = halfTick & sckReg;
  assign mDone    = mFall && (bitCnt == LAST_BIT);

  // slave sequencing
  assign slvOn = spiEn & ~mstEn & ~nssSync;
  assign sRise = slvOn & slvSckRise;
  assign sFall = slvOn & slvSckFall;
  assign sDone = sFall && (bitCnt == LAST_BIT);

  assign faultNow   = spiEn & mstEn & ~nssSync;
  assign abortNow   = busy & (faultNow | ~spiEn | ~mstEn);
  assign inProgress = busy | (slvOn && (bitCnt != '0));
  assign startNow   = dataWr & ~inProgress & spiEn & mstEn & nssSync;
  assign xferDone   = (mDone & ~abortNow) | sDone;
  assign rxFullEff  = rxFull & ~dataRd;

  always_comb begin
    strobe.loadTx     = dataWr & ~inProgress;
    strobe.sampleBit  = (mRise & ~abortNow) | sRise;
    strobe.shiftBit   = (mFall & ~abortNow) | sFall;
    strobe.commitRx   = xferDone & ~rxFullEff;
    strobe.fromMaster = mstEn;
  end

  // transfer state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sckReg <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      if (abortNow)      busy <= 1'b0;
      else if (startNow) busy <= 1'b1;
      else if (mDone)    busy <= 1'b0;

      if (!busy || abortNow) sckReg <= 1'b0;
      else if (halfTick)     sckReg <= ~sckReg;

      if (!busy || halfTick) divCnt <= '0;
      else                   divCnt <= divCnt + 1'b1;

      if (abortNow || startNow)
        bitCnt <= '0;
      else if (busy) begin
        if (mFall) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end else if (!slvOn)
        bitCnt <= '0;
      else if (sFall)
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  // control bits and sticky flags: a hardware set wins over a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiEn  <= 1'b0;
      mstEn  <= 1'b0;
      fDone  <= 1'b0;
      fWcol  <= 1'b0;
      fFalt  <= 1'b0;
      fOvrn  <= 1'b0;
      rxFull <= 1'b0;
    end else begin
      if (ctrlWr) begin
        spiEn <= regWrData[F_EN];
        mstEn <= regWrData[F_MST];
      end
      if (xferDone)              fDone <= 1'b1;
      else if (ctrlWr)           fDone <= regWrData[F_DONE];
      if (dataWr && inProgress)  fWcol <= 1'b1;
      else if (ctrlWr)           fWcol <= regWrData[F_WCOL];
      if (faultNow)              fFalt <= 1'b1;
      else if (ctrlWr)           fFalt <= regWrData[F_FALT];
      if (xferDone && rxFullEff) fOvrn <= 1'b1;
      else if (ctrlWr)           fOvrn <= regWrData[F_OVRN];

      if (strobe.commitRx) rxFull <= 1'b1;
      else if (dataRd)     rxFull <= 1'b0;
    end
  end

  always_comb begin
    ctrlView         = '0;
    ctrlView[F_DONE] = fDone;
    ctrlView[F_WCOL] = fWcol;
    ctrlView[F_FALT] = fFalt;
    ctrlView[F_OVRN] = fOvrn;
    ctrlView[F_BUSY] = busy;
    ctrlView[F_SEL]  = ~nssSync;
    ctrlView[F_MST]  = mstEn;
    ctrlView[F_EN]   = spiEn;
  end

  assign irq    = fDone | fWcol | fFalt | fOvrn;
  assign sckOut = sckReg;
endmodule

// File: rtl/spiPort.sv
module spiPort
  import spiPortPkg::*;
#(
  parameter int unsigned SCK_HALF    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              irq,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              masterMiso,
  input  logic              nssIn,
  input  logic              slaveSck,
  input  logic              slaveMosi,
  output logic              misoOut,
  output logic              misoDrive
);
  dpStrobeT          strobe;
  logic [BYTE_W-1:0] ctrlView, rxBuf;
  logic              busy, xferDone, inProgress, rxFull;
  logic              nssSync, slvSckRise, slvSckFall, shiftMsb;

  spiPortCtrl #(.SCK_HALF(SCK_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .nssSync(nssSync),
    .slvSckRise(slvSckRise), .slvSckFall(slvSckFall), .strobe(strobe),
    .ctrlView(ctrlView), .sckOut(sckOut), .busy(busy), .xferDone(xferDone),
    .inProgress(inProgress), .rxFull(rxFull), .irq(irq)
  );

  spiPortDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(regWrData),
    .masterMiso(masterMiso), .nssIn(nssIn), .slaveSck(slaveSck),
    .slaveMosi(slaveMosi), .shiftMsb(shiftMsb), .rxBuf(rxBuf),
    .nssSync(nssSync), .slvSckRise(slvSckRise), .slvSckFall(slvSckFall)
  );

  assign regRdData = !regRdEn ? '0 : (regAddr ? rxBuf : ctrlView);
  assign mosiOut   = busy & shiftMsb;
  assign misoOut   = shiftMsb;
  assign misoDrive = ctrlView[F_EN] & ~ctrlView[F_MST] & ~nssSync;
endmodule

// File: rtl/spiPortChk.sv
module spiPortChk
  import spiPortPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              sckOut,
  input logic              spiEn,
  input logic              mstEn,
  input logic              doneFlag,
  input logic              wcolFlag,
  input logic              faltFlag,
  input logic              ovrnFlag,
  input logic              ctrlWr,
  input logic              dataWr,
  input logic              dataRd,
  input logic              inProgress,
  input logic              nssSync,
  input logic              xferDone,
  input logic              rxFull,
  input logic [BYTE_W-1:0] rxBuf
);
  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckOut);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(spiEn && mstEn)) |=> !busy);

  assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> doneFlag);

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !ctrlWr) |=> doneFlag);

  assert_collision_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && inProgress) |=> wcolFlag);

  assert_fault_abort_R5: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && mstEn && !nssSync) |=> (faltFlag && !busy));

  assert_overrun_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && rxFull && !dataRd) |=> (ovrnFlag && $stable(rxBuf)));

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !spiEn |-> !xferDone);
endmodule

bind spiPort spiPortChk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sckOut(sckOut),
  .spiEn(ctrlView[0]), .mstEn(ctrlView[1]),
  .doneFlag(ctrlView[7]), .wcolFlag(ctrlView[6]),
  .faltFlag(ctrlView[5]), .ovrnFlag(ctrlView[4]),
  .ctrlWr(regWrEn & ~regAddr), .dataWr(regWrEn & regAddr),
  .dataRd(regRdEn & regAddr), .inProgress(inProgress),
  .nssSync(nssSync), .xferDone(xferDone), .rxFull(rxFull), .rxBuf(rxBuf)
);

// File: tb/test_spiPort.sv
module test_spiPort;
  localparam int unsigned SCK_HALF = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0, regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irq, sckOut, mosiOut, misoOut, misoDrive;
  logic       masterMiso = 1'b0, nssIn = 1'b1, slaveSck = 1'b0, slaveMosi = 1'b0;

  spiPort #(.SCK_HALF(SCK_HALF)) i_spiPort (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irq(irq), .sckOut(sckOut), .mosiOut(mosiOut), .masterMiso(masterMiso),
    .nssIn(nssIn), .slaveSck(slaveSck), .slaveMosi(slaveMosi),
    .misoOut(misoOut), .misoDrive(misoDrive)
  );

  int  checks = 0, fails = 0;
  bit  ended = 0;
  int  sckHighCnt = 0;

  always @(negedge clk) if (sckOut) sckHighCnt <= sckHighCnt + 1;

  function automatic logic [7:0] ctrlExp(bit done, bit wcol, bit falt, bit ovrn,
                                         bit busy, bit sel, bit mst, bit en);
    return {done, wcol, falt, ovrn, busy, sel, mst, en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic regWrite(input logic addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic addr, output logic [7:0] data);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = addr;
    #1 data = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int k = 0; k < 200; k++) begin
      regRead(1'b0, v);
      if (!v[3]) break;
    end
  endtask

  // master transfer with bench acting as the far slave
  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] slv,
                            input bit collide, input logic [7:0] cByte,
                            output logic [7:0] seen);
    masterMiso = slv[7];
    regWrite(1'b1, tx);
    for (int i = 0; i < 8; i++) begin
      @(posedge sckOut);
      seen[7-i] = mosiOut;
      if (collide && i == 0) regWrite(1'b1, cByte);
      @(negedge sckOut);
      if (i < 7) masterMiso = slv[6-i];
    end
    repeat (4) @(posedge clk);
  endtask

  // bench acts as master toward the port in slave mode
  task automatic slaveXfer(input logic [7:0] mosiByte, output logic [7:0] misoSeen);
    nssIn = 1'b0;
    repeat (6) @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      slaveMosi = mosiByte[7-i];
      repeat (8) @(posedge clk);
      #1 misoSeen[7-i] = misoOut;
      slaveSck = 1'b1;
      repeat (8) @(posedge clk);
      #1 slaveSck = 1'b0;
    end
    repeat (8) @(posedge clk);
    nssIn = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] v, tx, slv, seen, seen2;
    int seedVal;
    int hiBefore;
    seedVal = $urandom(32'h1234_5eed);

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    regRead(1'b0, v);
    check("R1 ctrl after reset", v, 8'h00);
    check("R1 irq after reset", irq, 1'b0);
    check("R1 sck after reset", sckOut, 1'b0);

    // R2 read-only bits ignore writes, others read back
    regWrite(1'b0, 8'h0C);
    regRead(1'b0, v);
    check("R2 read-only busy/sel", v, 8'h00);
    regWrite(1'b0, 8'hFF);
    regRead(1'b0, v);
    check("R2 writable fields", v, ctrlExp(1,1,1,1,0,0,1,1));
    check("R3 irq with flags set", irq, 1'b1);
    regWrite(1'b0, 8'h03);
    regRead(1'b0, v);
    check("R3 flags cleared by write", v, ctrlExp(0,0,0,0,0,0,1,1));
    check("R3 irq low after clear", irq, 1'b0);

    // R7 busy during master transfer, R8 sck high time
    masterMiso = 1'b0;
    hiBefore = sckHighCnt;
    regWrite(1'b1, 8'hA5);
    repeat (2) @(posedge clk);
    regRead(1'b0, v);
    check("R7 busy mid transfer", v, ctrlExp(0,0,0,0,1,0,1,1));
    waitIdle();
    regRead(1'b0, v);
    check("R7 busy cleared, R3 done set", v, ctrlExp(1,0,0,0,0,0,1,1));
    check("R8 sck high clocks", sckHighCnt - hiBefore, 8 * SCK_HALF);
    check("R7 sck idle low", sckOut, 1'b0);
    regRead(1'b1, v);
    check("R8 rx all zero", v, 8'h00);
    regWrite(1'b0, 8'h03);

    // R8 random master transfers
    for (int n = 0; n < 6; n++) begin
      tx  = 8'($urandom);
      slv = 8'($urandom);
      masterXfer(tx, slv, 1'b0, 8'h00, seen);
      check("R8 mosi byte msb first", seen, tx);
      regRead(1'b0, v);
      check("R3 done after master xfer", v, ctrlExp(1,0,0,0,0,0,1,1));
      check("R3 irq on done", irq, 1'b1);
      regRead(1'b1, v);
      check("R8 rx byte", v, slv);
      regWrite(1'b0, 8'h03);
      check("R3 irq cleared", irq, 1'b0);
    end

    // R4 collision: second write discarded
    masterXfer(8'h3C, 8'h96, 1'b1, 8'hFF, seen);
    check("R4 original byte sent", seen, 8'h3C);
    regRead(1'b0, v);
    check("R4 collision flag", v, ctrlExp(1,1,0,0,0,0,1,1));
    regRead(1'b1, v);
    check("R4 rx unaffected", v, 8'h96);
    regWrite(1'b0, 8'h03);

    // R6 overrun keeps old byte
    masterXfer(8'h11, 8'h5A, 1'b0, 8'h00, seen);
    masterXfer(8'h22, 8'hC3, 1'b0, 8'h00, seen2);
    regRead(1'b0, v);
    check("R6 overrun flag", v, ctrlExp(1,0,0,1,0,0,1,1));
    regRead(1'b1, v);
    check("R6 old byte kept", v, 8'h5A);
    regWrite(1'b0, 8'h03);
    regRead(1'b0, v);
    check("R6 overrun cleared", v, ctrlExp(0,0,0,0,0,0,1,1));

    // R5 mode fault aborts master transfer
    masterMiso = 1'b0;
    regWrite(1'b1, 8'hF0);
    @(posedge sckOut);
    nssIn = 1'b0;
    repeat (6) @(posedge clk);
    regRead(1'b0, v);
    check("R5 fault, abort, selected", v, ctrlExp(0,0,1,0,0,1,1,1));
    check("R5 sck low after abort", sckOut, 1'b0);
    check("R5 irq on fault", irq, 1'b1);
    nssIn = 1'b1;
    repeat (6) @(posedge clk);
    regWrite(1'b0, 8'h01);
    regRead(1'b0, v);
    check("R5 fault cleared, slave mode", v, ctrlExp(0,0,0,0,0,0,0,1));

    // R9 selected flag follows select input
    nssIn = 1'b0;
    repeat (6) @(posedge clk);
    regRead(1'b0, v);
    check("R9 selected when low", v, ctrlExp(0,0,0,0,0,1,0,1));
    nssIn = 1'b1;
    repeat (6) @(posedge clk);
    regRead(1'b0, v);
    check("R9 deselected when high", v, ctrlExp(0,0,0,0,0,0,0,1));

    // R9 random slave transfers
    for (int n = 0; n < 4; n++) begin
      tx  = 8'($urandom);
      slv = 8'($urandom);
      regWrite(1'b1, tx);
      slaveXfer(slv, seen);
      check("R9 miso byte", seen, tx);
      regRead(1'b0, v);
      check("R3 done after slave xfer", v, ctrlExp(1,0,0,0,0,0,0,1));
      regRead(1'b1, v);
      check("R9 slave rx byte", v, slv);
      regWrite(1'b0, 8'h01);
    end

    // R10 disabled port ignores slave clocking
    regWrite(1'b0, 8'h00);
    regWrite(1'b1, 8'h77);
    slaveXfer(8'hE1, seen);
    regRead(1'b0, v);
    check("R10 no flags when disabled", v, 8'h00);
    check("R10 irq low when disabled", irq, 1'b0);
    regRead(1'b1, v);
    check("R10 rx unchanged", v, slv);

    finishRun();
  end
endmodule